// File: doc/BRIEF.md
# Dual Manchester Energy Frame Receiver

This block takes two redundant serial lines that each carry the same stream of machine-energy frames, recovers the Manchester bit stream on each, and accepts a frame only if its fixed marker bits and its CRC-8 are right. Every link tracks two kinds of silence on its own. The first is the time since the link last delivered a good frame. The second is the time since the toggle bit last changed: the sender flips that bit each time it publishes a new energy value. Each link has saturating counters for CRC failures, frame timeouts and toggle timeouts.

A selector forwards the energy value of link A while A is healthy. If A is not healthy it forwards link B. A fixed step table reduces the chosen 16-bit value to a 5-bit level. When neither link is healthy, the output is forced to the highest level, which is the most conservative value for the threshold logic downstream, and a failure flag is raised.

All timing is counted in core clock cycles. `SPB` is the number of clocks per bit. `FRAME_TO` and `TOGGLE_TO` are the two timeout windows.

Top module: `emfr_dual_rx`

## Requirements
- R1: A line is idle low and a frame starts on its first rising edge. Each bit lasts `SPB` clocks, and bits arrive most significant first. A 1 is high in the first half of the bit and low in the second half; a 0 is the reverse. A bit whose two halves are equal aborts the frame, and the aborted frame leaves the stored value and all counters unchanged.
- R2: Frame bits are numbered 31 (first) down to 0. Bits 31:28 must be 1001 and bits 27:25 must be 000. Bit 24 is the toggle bit, bits 23:8 are the energy value and bits 7:0 are the CRC. A frame with a wrong marker field is dropped and is not counted anywhere.
- R3: The CRC is CRC-8 with polynomial 0x07 and initial value 0, computed over bits 31:8 most significant bit first. A frame with a correct marker field but a wrong CRC is dropped, and that link's CRC counter goes up by one.
- R4: If a link receives no good frame for `FRAME_TO` cycles, its frame-timeout flag is set and its frame-timeout counter goes up once. The next good frame on that link clears the flag.
- R5: If a link receives no good frame with a changed toggle bit for `TOGGLE_TO` cycles, its toggle-timeout flag is set and its toggle-timeout counter goes up once. A good frame whose toggle bit differs from the previous good frame clears the flag. The first good frame after reset counts as a change.
- R6: A link is healthy when it has received at least one good frame since reset and neither of its timeout flags is set.
- R7: When link A is healthy, its value is used and `selLinkB` is 0. When only link B is healthy, B's value is used and `selLinkB` is 1.
- R8: With a healthy link selected, `level` is floor(energy / `ENERGY_STEP`), capped at 31, and `levelValid` is 1.
- R9: When neither link is healthy, `level` is 31, `levelValid` is 0 and `allFailed` is 1.
- R10: After reset, all counters and timeout flags are 0, no link is healthy, `level` is 31, `levelValid` is 0 and `allFailed` is 1.
- R11: Every counter stops at its maximum value, 2^`CNT_W` - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineA | input | 1 | Serial line of link A |
| lineB | input | 1 | Serial line of link B |
| level | output | 5 | Energy level of the selected link |
| levelValid | output | 1 | A healthy link drives `level` |
| selLinkB | output | 1 | Link B is the selected source |
| allFailed | output | 1 | Neither link is healthy |
| linkHealthy | output | 2 | Health of each link, bit 0 = A |
| frameTimeout | output | 2 | Frame-timeout flag of each link, bit 0 = A |
| toggleTimeout | output | 2 | Toggle-timeout flag of each link, bit 0 = A |
| crcCntA | output | CNT_W | CRC failures on A |
| crcCntB | output | CNT_W | CRC failures on B |
| frameToCntA | output | CNT_W | Frame timeouts on A |
| frameToCntB | output | CNT_W | Frame timeouts on B |
| toggleToCntA | output | CNT_W | Toggle timeouts on A |
| toggleToCntB | output | CNT_W | Toggle timeouts on B |

## Verification
If the bit-phase counter or the shift register slips, good frames stop being accepted. At the ports this shows as an unchanged `level` within one frame time, followed by a frame timeout after `FRAME_TO` cycles. A wrong CRC or marker evaluation shows up within one frame, either as a counter that moves when it should not or as a level that follows a corrupted frame. A wrong timer or toggle reference shows up as a health flag that changes state on the wrong side of the timeout window. The selection and fallback logic is visible one cycle after the health inputs change. The bench therefore compares level, selection, flags and counters against its own model after every frame and after each timeout window.

// File: rtl/emfr_pkg.sv
package emfr_pkg;

  localparam int FRAME_BITS = 32;
  localparam int ENERGY_W   = 16;
  localparam logic [6:0] MARKER = 7'b1001_000;

  typedef struct packed {
    logic bitStrobe;
    logic bitVal;
    logic frameEnd;
  } rxStrobe_t;

  function automatic logic [7:0] crc8Calc(input logic [23:0] data);
    logic [7:0] acc;
    logic       fb;
    acc = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      fb  = acc[7] ^ data[i];
      acc = {acc[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return acc;
  endfunction

endpackage

// File: rtl/emfr_bit_ctrl.sv
module emfr_bit_ctrl
  import emfr_pkg::*;
#(
  parameter int SPB = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineIn,
  output rxStrobe_t strb
);

  localparam int PW = $clog2(SPB);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] PH_FIRST = PW'(SPB / 4);
  localparam logic [PW-1:0] PH_SECOND = PW'((3 * SPB) / 4);
  localparam logic [PW-1:0] PH_LAST = PW'(SPB - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} ctrlState_t;

  ctrlState_t      state;
  logic [1:0]      syncQ;
  logic            linePrev;
  logic            firstHalf;
  logic [PW-1:0]   phase;
  logic [BW-1:0]   bitCnt;
  logic            lineS;

  assign lineS = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      syncQ     <= '0;
      linePrev  <= 1'b0;
      firstHalf <= 1'b0;
      phase     <= '0;
      bitCnt    <= '0;
    end else begin
      syncQ    <= {syncQ[0], lineIn};
      linePrev <= lineS;
      case (state)
        S_IDLE: begin
          if (lineS && !linePrev) begin
            state  <= S_RUN;
            phase  <= PW'(1);
            bitCnt <= '0;
          end
        end
        S_RUN: begin
          if (phase == PH_LAST) begin
            phase  <= '0;
            bitCnt <= bitCnt + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
          if (phase == PH_FIRST) firstHalf <= lineS;
          if (phase == PH_SECOND) begin
            if (lineS == firstHalf) state <= S_IDLE;
            else if (bitCnt == BW'(FRAME_BITS - 1)) state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.bitStrobe = (state == S_RUN) && (phase == PH_SECOND) && (lineS != firstHalf);
    strb.bitVal    = firstHalf;
    strb.frameEnd  = (state == S_DONE);
  end

endmodule

// File: rtl/emfr_link_data.sv
module emfr_link_data
  import emfr_pkg::*;
#(
  parameter int FRAME_TO  = 24000,
  parameter int TOGGLE_TO = 2000000,
  parameter int CNT_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strb,
  output logic [ENERGY_W-1:0] energy,
  output logic                healthy,
  output logic                frameTo,
  output logic                togTo,
  output logic [CNT_W-1:0]    crcCnt,
  output logic [CNT_W-1:0]    ftCnt,
  output logic [CNT_W-1:0]    ttCnt
);

  localparam int FW = $clog2(FRAME_TO + 1);
  localparam int TW = $clog2(TOGGLE_TO + 1);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FW-1:0]         frameTimer;
  logic [TW-1:0]         togTimer;
  logic                  haveData;
  logic                  lastTog;
  logic                  structOk;
  logic                  crcOk;
  logic                  goodFrame;
  logic                  crcBad;
  logic                  togChange;

  always_comb begin
    structOk  = (shiftReg[31:25] == MARKER);
    crcOk     = (shiftReg[7:0] == crc8Calc(shiftReg[31:8]));
    goodFrame = strb.frameEnd && structOk && crcOk;
    crcBad    = strb.frameEnd && structOk && !crcOk;
    togChange = goodFrame && (!haveData || (shiftReg[24] != lastTog));
  end

  assign healthy = haveData && !frameTo && !togTo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      energy     <= '0;
      haveData   <= 1'b0;
      lastTog    <= 1'b0;
      frameTimer <= '0;
      frameTo    <= 1'b0;
      togTimer   <= '0;
      togTo      <= 1'b0;
      crcCnt     <= '0;
      ftCnt      <= '0;
      ttCnt      <= '0;
    end else begin
      if (strb.bitStrobe) shiftReg <= {shiftReg[FRAME_BITS-2:0], strb.bitVal};

      if (crcBad && (crcCnt != '1)) crcCnt <= crcCnt + 1'b1;

      if (goodFrame) begin
        energy     <= shiftReg[23:8];
        haveData   <= 1'b1;
        lastTog    <= shiftReg[24];
        frameTimer <= '0;
        frameTo    <= 1'b0;
      end else if (!frameTo) begin
        if (frameTimer == FW'(FRAME_TO - 1)) begin
          frameTo <= 1'b1;
          if (ftCnt != '1) ftCnt <= ftCnt + 1'b1;
        end else begin
          frameTimer <= frameTimer + 1'b1;
        end
      end

      if (togChange) begin
        togTimer <= '0;
        togTo    <= 1'b0;
      end else if (!togTo) begin
        if (togTimer == TW'(TOGGLE_TO - 1)) begin
          togTo <= 1'b1;
          if (ttCnt != '1) ttCnt <= ttCnt + 1'b1;
        end else begin
          togTimer <= togTimer + 1'b1;
        end
      end
    end
  end

  // R3: the CRC counter only ever moves up by one
  p_crc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (crcCnt != $past(crcCnt)) |-> (crcCnt == $past(crcCnt) + 1'b1));

  // R11: a full counter stays full
  p_crc_hold_full_r11: assert property (@(posedge clk) disable iff (!rstN)
    (crcCnt == '1) |=> (crcCnt == '1));

  // R4: entering frame timeout bumps its counter unless it is full
  p_frame_to_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameTo) |-> ((ftCnt == $past(ftCnt) + 1'b1) || ($past(ftCnt) == '1)));

  // R5: entering toggle timeout bumps its counter unless it is full
  p_toggle_to_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(togTo) |-> ((ttCnt == $past(ttCnt) + 1'b1) || ($past(ttCnt) == '1)));

endmodule

// File: rtl/emfr_select.sv
module emfr_select
  import emfr_pkg::*;
#(
  parameter int ENERGY_STEP = 240,
  parameter int LEVELS      = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                healthy,
  input  logic [ENERGY_W-1:0]       energyA,
  input  logic [ENERGY_W-1:0]       energyB,
  output logic [$clog2(LEVELS)-1:0] level,
  output logic                      levelValid,
  output logic                      selB,
  output logic                      allFailed
);

  localparam int LW = $clog2(LEVELS);
  localparam logic [LW-1:0] LEVEL_MAX = LW'(LEVELS - 1);

  logic                  useB;
  logic [ENERGY_W-1:0]   selEnergy;
  logic [LEVELS-1:1]     aboveStep;
  logic [LW-1:0]         convLevel;

  assign useB      = !healthy[0] && healthy[1];
  assign selEnergy = useB ? energyB : energyA;

  for (genvar k = 1; k < LEVELS; k++) begin : g_step
    assign aboveStep[k] = (32'(selEnergy) >= 32'(k * ENERGY_STEP));
  end

  always_comb begin
    convLevel = '0;
    for (int k = 1; k < LEVELS; k++) convLevel = convLevel + LW'(aboveStep[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level      <= LEVEL_MAX;
      levelValid <= 1'b0;
      selB       <= 1'b0;
      allFailed  <= 1'b1;
    end else if (healthy == 2'b00) begin
      level      <= LEVEL_MAX;
      levelValid <= 1'b0;
      selB       <= 1'b0;
      allFailed  <= 1'b1;
    end else begin
      level      <= convLevel;
      levelValid <= 1'b1;
      selB       <= useB;
      allFailed  <= 1'b0;
    end
  end

  // R7: a healthy link A always wins
  p_prefer_a_r7: assert property (@(posedge clk) disable iff (!rstN)
    healthy[0] |=> (!selB && levelValid));

  // R7: link B takes over only when A is down
  p_use_b_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!healthy[0] && healthy[1]) |=> selB);

  // R9: no healthy link means the safe level
  p_fallback_r9: assert property (@(posedge clk) disable iff (!rstN)
    (healthy == 2'b00) |=> (allFailed && !levelValid && (level == LEVEL_MAX)));

endmodule

// File: rtl/emfr_dual_rx.sv
module emfr_dual_rx
  import emfr_pkg::*;
#(
  parameter int SPB         = 8,
  parameter int FRAME_TO    = 24000,
  parameter int TOGGLE_TO   = 2000000,
  parameter int CNT_W       = 8,
  parameter int ENERGY_STEP = 240,
  parameter int LEVELS      = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lineA,
  input  logic                      lineB,
  output logic [$clog2(LEVELS)-1:0] level,
  output logic                      levelValid,
  output logic                      selLinkB,
  output logic                      allFailed,
  output logic [1:0]                linkHealthy,
  output logic [1:0]                frameTimeout,
  output logic [1:0]                toggleTimeout,
  output logic [CNT_W-1:0]          crcCntA,
  output logic [CNT_W-1:0]          crcCntB,
  output logic [CNT_W-1:0]          frameToCntA,
  output logic [CNT_W-1:0]          frameToCntB,
  output logic [CNT_W-1:0]          toggleToCntA,
  output logic [CNT_W-1:0]          toggleToCntB
);

  localparam int LINKS = 2;

  logic [LINKS-1:0]    lines;
  rxStrobe_t           strb     [LINKS];
  logic [ENERGY_W-1:0] energy   [LINKS];
  logic [CNT_W-1:0]    crcCnt   [LINKS];
  logic [CNT_W-1:0]    ftCnt    [LINKS];
  logic [CNT_W-1:0]    ttCnt    [LINKS];

  assign lines = {lineB, lineA};

  for (genvar g = 0; g < LINKS; g++) begin : g_link
    emfr_bit_ctrl #(.SPB(SPB)) u_ctrl (
      .clk   (clk),
      .rstN  (rstN),
      .lineIn(lines[g]),
      .strb  (strb[g])
    );

    emfr_link_data #(
      .FRAME_TO (FRAME_TO),
      .TOGGLE_TO(TOGGLE_TO),
      .CNT_W    (CNT_W)
    ) u_data (
      .clk    (clk),
      .rstN   (rstN),
      .strb   (strb[g]),
      .energy (energy[g]),
      .healthy(linkHealthy[g]),
      .frameTo(frameTimeout[g]),
      .togTo  (toggleTimeout[g]),
      .crcCnt (crcCnt[g]),
      .ftCnt  (ftCnt[g]),
      .ttCnt  (ttCnt[g])
    );
  end

  emfr_select #(.ENERGY_STEP(ENERGY_STEP), .LEVELS(LEVELS)) u_sel (
    .clk       (clk),
    .rstN      (rstN),
    .healthy   (linkHealthy),
    .energyA   (energy[0]),
    .energyB   (energy[1]),
    .level     (level),
    .levelValid(levelValid),
    .selB      (selLinkB),
    .allFailed (allFailed)
  );

  assign crcCntA      = crcCnt[0];
  assign crcCntB      = crcCnt[1];
  assign frameToCntA  = ftCnt[0];
  assign frameToCntB  = ftCnt[1];
  assign toggleToCntA = ttCnt[0];
  assign toggleToCntB = ttCnt[1];

endmodule

// File: tb/emfr_dual_rx_bench.sv
module emfr_dual_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SPB        = 8;
  localparam int FRAME_TO   = 1200;
  localparam int TOGGLE_TO  = 4000;
  localparam int CNT_W      = 4;
  localparam int STEP       = 240;
  localparam int GAP        = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineA = 1'b0;
  logic lineB = 1'b0;
  logic [4:0] level;
  logic levelValid, selLinkB, allFailed;
  logic [1:0] linkHealthy, frameTimeout, toggleTimeout;
  logic [CNT_W-1:0] crcCntA, crcCntB, frameToCntA, frameToCntB, toggleToCntA, toggleToCntB;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic togA = 1'b0;
  logic togB = 1'b0;
  int lastEA = 0;
  int lastEB = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  emfr_dual_rx #(
    .SPB(SPB), .FRAME_TO(FRAME_TO), .TOGGLE_TO(TOGGLE_TO),
    .CNT_W(CNT_W), .ENERGY_STEP(STEP), .LEVELS(32)
  ) u_emfr_dual_rx (
    .clk(clk), .rstN(rstN), .lineA(lineA), .lineB(lineB),
    .level(level), .levelValid(levelValid), .selLinkB(selLinkB), .allFailed(allFailed),
    .linkHealthy(linkHealthy), .frameTimeout(frameTimeout), .toggleTimeout(toggleTimeout),
    .crcCntA(crcCntA), .crcCntB(crcCntB), .frameToCntA(frameToCntA), .frameToCntB(frameToCntB),
    .toggleToCntA(toggleToCntA), .toggleToCntB(toggleToCntB)
  );

  function automatic logic [7:0] refCrc(input logic [23:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      if (r[7] != d[i]) r = (r << 1) ^ 8'h07;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] mkFrame(input logic [3:0] hdr, input logic tog,
                                          input int e, input logic [7:0] crcFlip);
    logic [23:0] body = {hdr, 3'b000, tog, 16'(e)};
    return {body, refCrc(body) ^ crcFlip};
  endfunction

  function automatic int expLevel(input int e);
    int l = e / STEP;
    return (l > 31) ? 31 : l;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendFrame(input int link, input logic [31:0] w, input int badBit);
    for (int i = 31; i >= 0; i--) begin
      for (int h = 0; h < SPB; h++) begin
        logic v;
        @(negedge clk);
        if (h < SPB / 2) v = w[i];
        else v = (i == badBit) ? w[i] : ~w[i];
        if (link == 0) lineA = v; else lineB = v;
      end
    end
    @(negedge clk);
    lineA = (link == 0) ? 1'b0 : lineA;
    lineB = (link == 1) ? 1'b0 : lineB;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic goodA(input int e);
    togA = ~togA;
    sendFrame(0, mkFrame(4'b1001, togA, e, 8'h00), -1);
    lastEA = e;
  endtask

  task automatic goodB(input int e);
    togB = ~togB;
    sendFrame(1, mkFrame(4'b1001, togB, e, 8'h00), -1);
    lastEB = e;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    int directed[6] = '{0, 239, 240, 7439, 7440, 65535};
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 level", level, 31);
    chk("R10 valid", levelValid, 0);
    chk("R10 allFailed", allFailed, 1);
    chk("R10 healthy", linkHealthy, 0);
    chk("R10 counters", crcCntA + crcCntB + frameToCntA + frameToCntB + toggleToCntA + toggleToCntB, 0);

    // R6 R8 R5: first good frame on A makes it usable
    goodA(5000);
    chk("R6 healthy A", linkHealthy[0], 1);
    chk("R8 level A", level, expLevel(5000));
    chk("R8 valid", levelValid, 1);
    chk("R5 first frame no toggle timeout", toggleTimeout[0], 0);

    // R7: B frame does not displace healthy A
    goodB(20000);
    chk("R7 A kept", level, expLevel(5000));
    chk("R7 selB low", selLinkB, 0);

    // R8 R2 R1: directed boundaries then random values
    for (int i = 0; i < 18; i++) begin
      int e = (i < 6) ? directed[i] : int'($urandom_range(0, 65535));
      goodA(e);
      chk("R8 conversion", level, expLevel(e));
      goodB(int'($urandom_range(0, 65535)));
      chk("R7 A still selected", level, expLevel(e));
    end

    // R3: bad CRC on A is counted and ignored
    sendFrame(0, mkFrame(4'b1001, ~togA, 100, 8'h01), -1);
    chk("R3 crc count", crcCntA, 1);
    chk("R3 level unchanged", level, expLevel(lastEA));
    goodB(3000);
    goodA(2400);
    chk("R8 after recovery", level, 10);
    goodB(3000);

    // R2: wrong marker is dropped without counting
    sendFrame(0, mkFrame(4'b1011, ~togA, 9000, 8'h00), -1);
    chk("R2 crc count unchanged", crcCntA, 1);
    chk("R2 level unchanged", level, 10);
    goodB(3000);
    goodA(1200);
    chk("R2 receiver recovers", level, 5);
    goodB(3000);

    // R1: missing mid-bit transition aborts the frame
    sendFrame(0, mkFrame(4'b1001, ~togA, 9000, 8'h00), 0);
    chk("R1 aborted frame ignored", level, 5);
    chk("R1 crc count unchanged", crcCntA, 1);
    chk("R1 no frame timeout yet", frameTimeout[0], 0);
    goodB(3000);
    goodA(720);
    chk("R1 decode resumes", level, 3);

    // R4 R7: A goes silent, B takes over
    for (int i = 0; i < 6; i++) goodB(2500 + i * 240);
    chk("R4 A frame timeout", frameTimeout[0], 1);
    chk("R4 A frame timeout count", frameToCntA, 1);
    chk("R6 A unhealthy", linkHealthy[0], 0);
    chk("R7 B selected", selLinkB, 1);
    chk("R7 B level", level, expLevel(lastEB));
    chk("R8 valid on B", levelValid, 1);
    chk("R4 B no frame timeout", frameToCntB, 0);

    // R5 R9: B toggle stuck while A is dead
    for (int i = 0; i < 16; i++) sendFrame(1, mkFrame(4'b1001, togB, 4000, 8'h00), -1);
    chk("R5 B toggle timeout", toggleTimeout[1], 1);
    chk("R5 B toggle count", toggleToCntB, 1);
    chk("R5 A toggle count", toggleToCntA, 1);
    chk("R4 B frames still good", frameTimeout[1], 0);
    chk("R4 A count held", frameToCntA, 1);
    chk("R9 allFailed", allFailed, 1);
    chk("R9 level max", level, 31);
    chk("R9 valid low", levelValid, 0);

    // R4 R5 R7: A returns with a flipped toggle
    goodA(960);
    chk("R4 A timeout cleared", frameTimeout[0], 0);
    chk("R5 A toggle cleared", toggleTimeout[0], 0);
    chk("R7 back to A", selLinkB, 0);
    chk("R8 level A again", level, 4);
    chk("R9 allFailed cleared", allFailed, 0);

    // R11: CRC counter saturates
    for (int i = 0; i < 17; i++) sendFrame(1, mkFrame(4'b1001, togB, 10, 8'h80), -1);
    chk("R11 crc saturate", crcCntB, 15);

    done = 1'b1;
    finishRun();
  end

endmodule